// File: doc/BRIEF.md
# Single-Cycle 64-bit Load/Store Processor Core

This block is a small processor core that completes one instruction per clock. Each rising edge commits the instruction at the program counter. It supports five register-register arithmetic and logic operations, a doubleword load, a doubleword store, a branch on register equality and an absolute jump. The core holds the program counter, a 32 x 64-bit register file with two read ports and one write port, the ALU, the displacement sign extender, the next-PC selection and a two-level decoder. The first decoder level reads the opcode. The second reads the function field of register-register instructions.

Instruction memory and data memory are small arrays inside the core. While reset is held, a load port writes words into either memory. When reset is released, execution starts at address zero. Three groups of registered trace outputs report every commit one cycle later: the program counter, the register write and the memory write. An environment can follow the program on these outputs without any access to the internal state.

Instruction fields sit at fixed positions: opcode [31:26], first source [25:21], second source or load destination [20:16], destination [15:11], function [5:0], displacement [15:0] and jump index [25:0].

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, the PC, all 32 registers and the trace outputs are cleared. A load-port word is written at each clock where `ld_en` is high: to instruction word `ld_addr` when `ld_imem`=1 (the low 32 bits), otherwise to data word `ld_addr`.
- R2: Each cycle fetches the instruction word at index PC[IMEM_AW+1:2]. Any instruction that is not a taken branch or a jump advances the PC by 4.
- R3: Opcode 0x00 selects a register-register operation on rs and rt, written to rd. The function codes are: 0x2C add, 0x2E subtract (rs minus rt), 0x24 and, 0x25 or, 0x26 xor. Bits [10:6] must be zero.
- R4: Opcode 0x37 loads data word ((rs + sign-extended disp) >> 3) modulo the data depth into rt. The low three address bits are ignored.
- R5: Opcode 0x3F stores rt to the data word chosen as in R4. It writes no register.
- R6: Opcode 0x04 branches when rs equals rt. The target is PC + 4 + (sign-extended disp << 2), so the displacement may be negative.
- R7: Opcode 0x02 always jumps, to {(PC+4)[63:28], index, 2'b00}.
- R8: Register 0 reads as zero. Writes to it are dropped and are not reported on the trace.
- R9: Any other opcode, and any other function code or a nonzero [10:6] under opcode 0x00, performs no register write and no memory write.
- R10: After each edge, `pc_o` shows the new PC. `rf_we_o`/`rf_wa_o`/`rf_wd_o` show the register write of the instruction just committed. `dm_we_o`/`dm_addr_o`/`dm_wd_o` show its store, with `dm_addr_o` as the full effective address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; memories are preloaded while it is high |
| ld_en | input | 1 | Load-port write strobe |
| ld_imem | input | 1 | 1 selects instruction memory, 0 selects data memory |
| ld_addr | input | LD_AW | Word index of the load-port write |
| ld_data | input | 64 | Load-port write data (low 32 bits for instructions) |
| pc_o | output | XLEN | Current program counter |
| rf_we_o | output | 1 | A register was written by the last commit |
| rf_wa_o | output | 5 | Register written |
| rf_wd_o | output | XLEN | Value written |
| dm_we_o | output | 1 | Data memory was written by the last commit |
| dm_addr_o | output | XLEN | Effective store address |
| dm_wd_o | output | XLEN | Stored value |

## Verification
The bench runs the same program against two data images. The branch on equality is not taken on the first image and taken on the second. A wrong comparison therefore sends `pc_o` down the wrong path in one of the two runs. A load with a negative displacement reads a word stored earlier in the program. A sign-extension fault, or a wrong use of the low address bits, returns the wrong word. Subtraction with its operands swapped, a write to register 0 that is kept, or an unknown opcode or function that writes anyway all show up on the write trace. A store of a register at the start of the second run confirms that reset cleared the register file, because a stale value would appear on `dm_wd_o`. A branch backwards and two jumps check the target arithmetic in both directions.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam logic [5:0] OP_RRR  = 6'h00;
  localparam logic [5:0] OP_JMP  = 6'h02;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_LDD  = 6'h37;
  localparam logic [5:0] OP_STD  = 6'h3F;

  localparam logic [5:0] FN_ADD  = 6'h2C;
  localparam logic [5:0] FN_SUB  = 6'h2E;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR
  } alu_op_e;

  typedef struct packed {
    logic reg_wr;     // instruction writes a register
    logic mem_wr;     // instruction writes data memory
    logic wb_mem;     // write-back value comes from memory
    logic b_imm;      // ALU second operand is the displacement
    logic is_beq;
    logic is_jmp;
    logic is_rrr;     // function field selects the ALU operation
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OP_RRR: begin ctrl.reg_wr = 1'b1; ctrl.is_rrr = 1'b1; end
      OP_LDD: begin ctrl.reg_wr = 1'b1; ctrl.wb_mem = 1'b1; ctrl.b_imm = 1'b1; end
      OP_STD: begin ctrl.mem_wr = 1'b1; ctrl.b_imm = 1'b1; end
      OP_BEQ: ctrl.is_beq = 1'b1;
      OP_JMP: ctrl.is_jmp = 1'b1;
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_core_pkg::*;
(
  input  logic        is_rrr,
  input  logic [10:0] low_bits,   // shift-amount field and function code
  output alu_op_e     op,
  output logic        fn_ok
);
  always_comb begin
    op    = ALU_ADD;
    fn_ok = 1'b1;
    if (is_rrr) begin
      fn_ok = (low_bits[10:6] == 5'd0);
      unique case (low_bits[5:0])
        FN_ADD: op = ALU_ADD;
        FN_SUB: op = ALU_SUB;
        FN_AND: op = ALU_AND;
        FN_OR:  op = ALU_OR;
        FN_XOR: op = ALU_XOR;
        default: fn_ok = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int RA_W  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RA_W-1:0] ra1,
  input  logic [RA_W-1:0] ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [RA_W-1:0] wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 5,
  parameter int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic             ld_imem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [63:0]      ld_data,
  output logic [XLEN-1:0]  pc_o,
  output logic             rf_we_o,
  output logic [4:0]       rf_wa_o,
  output logic [XLEN-1:0]  rf_wd_o,
  output logic             dm_we_o,
  output logic [XLEN-1:0]  dm_addr_o,
  output logic [XLEN-1:0]  dm_wd_o
);
  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;
  localparam int NREGS  = 32;

  logic [31:0]     imem [IDEPTH];
  logic [XLEN-1:0] dmem [DDEPTH];

  logic [XLEN-1:0] pc, pc_next, pc_seq, br_tgt, j_tgt;
  logic [31:0]     instr;
  ctrl_t           ctrl;
  alu_op_e         alu_op;
  logic            fn_ok, reg_we, mem_we, take_br;
  logic [4:0]      rs, rt, rd, wa;
  logic [XLEN-1:0] rs_val, rt_val, disp, alu_b, alu_y, ld_val, wb_val;
  logic [DMEM_AW-1:0] d_idx;

  // fetch and field extraction
  assign instr = imem[pc[IMEM_AW+1:2]];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign disp  = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_main_dec u_mdec (.opcode(instr[31:26]), .ctrl(ctrl));

  sc_alu_dec u_adec (
    .is_rrr(ctrl.is_rrr), .low_bits(instr[10:0]), .op(alu_op), .fn_ok(fn_ok)
  );

  sc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst(rst), .ra1(rs), .ra2(rt), .rd1(rs_val), .rd2(rt_val),
    .we(reg_we), .wa(wa), .wd(wb_val)
  );

  // operand select in front of the ALU
  assign alu_b = ctrl.b_imm ? disp : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (.op(alu_op), .a(rs_val), .b(alu_b), .y(alu_y));

  // data memory read and write-back select
  assign d_idx  = alu_y[DMEM_AW+2:3];
  assign ld_val = dmem[d_idx];
  assign wb_val = ctrl.wb_mem ? ld_val : alu_y;
  assign wa     = ctrl.wb_mem ? rt : rd;
  assign reg_we = ctrl.reg_wr && fn_ok && (wa != 5'd0);
  assign mem_we = ctrl.mem_wr;

  // next program counter
  assign pc_seq  = pc + XLEN'(4);
  assign br_tgt  = pc_seq + {disp[XLEN-3:0], 2'b00};
  assign j_tgt   = {pc_seq[XLEN-1:28], instr[25:0], 2'b00};
  assign take_br = ctrl.is_beq && (rs_val == rt_val);

  always_comb begin
    if (ctrl.is_jmp)  pc_next = j_tgt;
    else if (take_br) pc_next = br_tgt;
    else              pc_next = pc_seq;
  end

  // instruction memory: load port only
  always_ff @(posedge clk) begin
    if (rst && ld_en && ld_imem) imem[ld_addr[IMEM_AW-1:0]] <= ld_data[31:0];
  end

  // data memory: single write port shared by load port and stores
  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_en && !ld_imem) dmem[ld_addr[DMEM_AW-1:0]] <= ld_data[XLEN-1:0];
    end else if (mem_we) begin
      dmem[d_idx] <= rt_val;
    end
  end

  // architectural PC and commit trace
  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      rf_we_o   <= 1'b0;
      rf_wa_o   <= '0;
      rf_wd_o   <= '0;
      dm_we_o   <= 1'b0;
      dm_addr_o <= '0;
      dm_wd_o   <= '0;
    end else begin
      pc        <= pc_next;
      rf_we_o   <= reg_we;
      rf_wa_o   <= wa;
      rf_wd_o   <= wb_val;
      dm_we_o   <= mem_we;
      dm_addr_o <= alu_y;
      dm_wd_o   <= rt_val;
    end
  end

  assign pc_o = pc;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc_o,
  input logic [31:0]     instr,
  input logic            rf_we_o,
  input logic [4:0]      rf_wa_o,
  input logic            dm_we_o
);
  logic known_op;
  assign known_op = (instr[31:26] == 6'h00) || (instr[31:26] == 6'h02) ||
                    (instr[31:26] == 6'h04) || (instr[31:26] == 6'h37) ||
                    (instr[31:26] == 6'h3F);

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> (pc_o == '0));

  p_pc_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'h00) |=> (pc_o == $past(pc_o) + XLEN'(4)));

  p_store_no_reg_r5: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'h3F) |=> (dm_we_o && !rf_we_o));

  p_jump_index_r7: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'h02) |=> (pc_o[27:0] == {$past(instr[25:0]), 2'b00}));

  p_no_r0_trace_r8: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (rf_wa_o != 5'd0));

  p_unknown_nop_r9: assert property (@(posedge clk) disable iff (rst)
    !known_op |=> (!rf_we_o && !dm_we_o));
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .pc_o(pc_o), .instr(instr),
  .rf_we_o(rf_we_o), .rf_wa_o(rf_wa_o), .dm_we_o(dm_we_o)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;
  localparam int IA = 6;
  localparam int DA = 5;
  localparam int ID = 1 << IA;
  localparam int DD = 1 << DA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0, ld_imem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [63:0] ld_data = '0;
  logic [63:0] pc_o, rf_wd_o, dm_addr_o, dm_wd_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_wa_o;

  always #2.5 clk = ~clk;

  sc_core #(.XLEN(64), .IMEM_AW(IA), .DMEM_AW(DA)) dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_imem(ld_imem), .ld_addr(ld_addr),
    .ld_data(ld_data), .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_wa_o(rf_wa_o),
    .rf_wd_o(rf_wd_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wd_o(dm_wd_o)
  );

  int n_chk = 0, n_err = 0;

  // reference state
  logic [31:0] prog [ID];
  logic [63:0] mreg [32];
  logic [63:0] mmem [DD];
  logic [63:0] mpc;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int d, input int s, input int t);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input logic [15:0] imm);
    return {op, 5'(s), 5'(t), imm};
  endfunction
  function automatic logic [31:0] enc_j(input int idx);
    return {6'h02, 26'(idx)};
  endfunction

  task automatic build_prog();
    for (int i = 0; i < ID; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(6'h3F, 0, 5, 16'd40);    // store r5: stale value would show missing clear
    prog[1]  = enc_i(6'h37, 0, 1, 16'd0);
    prog[2]  = enc_i(6'h37, 0, 2, 16'd8);
    prog[3]  = enc_i(6'h37, 0, 9, 16'd32);
    prog[4]  = enc_r(6'h2C, 3, 1, 2);
    prog[5]  = enc_r(6'h2E, 4, 2, 1);
    prog[6]  = enc_r(6'h24, 5, 1, 2);
    prog[7]  = enc_r(6'h25, 6, 1, 2);
    prog[8]  = enc_r(6'h26, 7, 1, 2);
    prog[9]  = enc_i(6'h3F, 0, 3, 16'd16);
    prog[10] = enc_r(6'h2C, 0, 1, 2);         // write to r0
    prog[11] = enc_i(6'h3F, 0, 0, 16'd24);    // store r0
    prog[12] = {6'h3E, 5'd1, 5'd13, 16'h0010}; // unknown opcode
    prog[13] = enc_r(6'h3F, 10, 1, 2);        // unknown function
    prog[14] = enc_i(6'h04, 1, 2, 16'd3);
    prog[15] = enc_i(6'h37, 9, 8, 16'hFFE8);  // negative displacement
    prog[16] = enc_i(6'h04, 1, 1, 16'd2);
    prog[17] = enc_r(6'h2C, 11, 1, 1);
    prog[18] = enc_r(6'h2C, 13, 2, 2);
    prog[19] = enc_r(6'h2C, 12, 8, 1);
    prog[20] = enc_j(24);
    prog[23] = enc_j(26);
    prog[24] = enc_i(6'h04, 0, 0, 16'hFFFE);  // backward branch
    prog[26] = enc_j(26);
  endtask

  task automatic load_word(input logic imem_sel, input int a, input logic [63:0] d);
    ld_en = 1'b1; ld_imem = imem_sel; ld_addr = 6'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic start_run(input logic [63:0] w0, input logic [63:0] w1);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < DD; i++) mmem[i] = 64'h0;
    mmem[0] = w0; mmem[1] = w1; mmem[4] = 64'd40;
    for (int i = 0; i < ID; i++) load_word(1'b1, i, {32'h0, prog[i]});
    for (int i = 0; i < DD; i++) load_word(1'b0, i, mmem[i]);
    for (int i = 0; i < 32; i++) mreg[i] = 64'h0;
    mpc = 64'h0;
    // R1: reset state at the ports
    chk("R1 pc", pc_o, 64'h0);
    chk("R1 rf_we", {63'h0, rf_we_o}, 64'h0);
    chk("R1 dm_we", {63'h0, dm_we_o}, 64'h0);
    rst = 1'b0;
  endtask

  // executes one instruction in the reference and compares after the edge
  task automatic step();
    logic [31:0] ins;
    logic [5:0]  op, fn;
    logic [63:0] a, b, sx, nxt, ea, res;
    logic        rwe, mwe;
    int          wreg;
    string       tag, ptag;
    ins = prog[mpc[IA+1:2]];
    op = ins[31:26]; fn = ins[5:0];
    a  = mreg[ins[25:21]]; b = mreg[ins[20:16]];
    sx = {{48{ins[15]}}, ins[15:0]};
    nxt = mpc + 64'd4; rwe = 1'b0; mwe = 1'b0; wreg = 0; res = 0; ea = a + sx;
    tag = "R9"; ptag = "R2";
    if (op == 6'h00) begin
      rwe = (ins[10:6] == 0); wreg = ins[15:11]; tag = "R3";
      case (fn)
        6'h2C: res = a + b;
        6'h2E: res = a - b;
        6'h24: res = a & b;
        6'h25: res = a | b;
        6'h26: res = a ^ b;
        default: begin rwe = 1'b0; tag = "R9"; end
      endcase
    end else if (op == 6'h37) begin
      rwe = 1'b1; wreg = ins[20:16]; res = mmem[(ea >> 3) % DD]; tag = "R4";
    end else if (op == 6'h3F) begin
      mwe = 1'b1; tag = (mpc == 0) ? "R1" : "R5";
    end else if (op == 6'h04) begin
      tag = "R6";
      if (a == b) begin nxt = mpc + 64'd4 + (sx << 2); ptag = "R6"; end
    end else if (op == 6'h02) begin
      tag = "R7"; ptag = "R7";
      nxt = {(mpc + 64'd4) >> 28, ins[25:0], 2'b00};
    end
    if (rwe && wreg == 0) begin rwe = 1'b0; tag = "R8"; end
    if (op == 6'h3F && ins[20:16] == 0) tag = "R8";
    if (rwe) mreg[wreg] = res;
    if (mwe) mmem[(ea >> 3) % DD] = b;
    mpc = nxt;
    @(negedge clk);
    chk({ptag, " pc"}, pc_o, mpc);
    // R10: trace of the instruction just committed
    chk({"R10/", tag, " rf_we"}, {63'h0, rf_we_o}, {63'h0, rwe});
    if (rwe) begin
      chk({"R10/", tag, " rf_wa"}, {59'h0, rf_wa_o}, 64'(wreg));
      chk({"R10/", tag, " rf_wd"}, rf_wd_o, res);
    end
    chk({"R10/", tag, " dm_we"}, {63'h0, dm_we_o}, {63'h0, mwe});
    if (mwe) begin
      chk({"R10/", tag, " dm_addr"}, dm_addr_o, ea);
      chk({"R10/", tag, " dm_wd"}, dm_wd_o, b);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    build_prog();
    repeat (3) @(negedge clk);
    // run 1: unequal operands, branch at word 14 falls through
    start_run(64'h8000_0000_0000_00FF, 64'h0123_4567_89AB_CDEF);
    for (int i = 0; i < 30; i++) step();
    // run 2: equal operands, branch at word 14 taken; registers must be clear again
    start_run(64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFF0);
    for (int i = 0; i < 30; i++) step();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule